// File: doc/BRIEF.md
# Processor Operating State Controller

This block tracks which operating state a small microcontroller core is in and drives the controls that follow from it. There are seven states: reset, exception handling, program execution, bus released, sleep, software standby and hardware standby. The state moves according to two active-low pins (reset and standby), a watchdog overflow pulse, a sleep-instruction strobe qualified by a standby-select bit, a bus request, a completion signal from exception handling, and two groups of interrupt request lines. One group is internal and one is external.

The two pins and all interrupt lines come from outside the clock domain. Each one passes through a two-flop synchronizer before use, and the rising edge of the reset pin is detected on the synchronized value. The watchdog pulse, the sleep strobe, the standby-select bit, the bus request and the done signal are already synchronous. The block reports its state as a one-hot vector and also gives an interrupt-mask flag and two clock enables, one for the core and one for the peripherals. The one-hot vector and these three outputs change on the same clock edge.

Top module: `opstate_ctrl`

## Requirements
- R1: A low synchronized reset pin moves the controller to the reset state from any state except hardware standby. The state changes on the third rising clock edge after the pin is sampled low.
- R2: A one-cycle watchdog pulse moves the controller to the reset state on the next edge from any state except hardware standby. With the reset pin high, exception handling follows one edge later.
- R3: The interrupt-mask output is high exactly when the controller is in the reset state.
- R4: The controller stays in reset while the synchronized reset pin is low. A low-to-high transition of that pin moves it to exception handling.
- R5: A low synchronized standby pin moves the controller to hardware standby from every state, and this takes precedence over the reset pin and the watchdog.
- R6: Hardware standby is left only for the reset state, and only when the synchronized standby pin is high while the synchronized reset pin is low. With both pins high, the controller stays in hardware standby.
- R7: In program execution, a sleep strobe moves the controller on the next edge to sleep when the standby-select bit is 0, and to software standby when it is 1.
- R8: Any internal or external interrupt request leads sleep to exception handling. Software standby leaves for exception handling only on an external request and ignores internal ones. Both exits happen three edges after the request is sampled.
- R9: In program execution, a bus request leads to the bus-released state on the next edge, and it wins over a sleep strobe in the same cycle. Bus released returns to program execution on the first cycle the request is low.
- R10: In exception handling, the done signal leads to program execution on the next edge.
- R11: The core clock enable is low in sleep, software standby and hardware standby, and high otherwise. The peripheral clock enable is low only in software standby and hardware standby.
- R12: The state vector is one-hot, with bit 0 reset, bit 1 exception handling, bit 2 program execution, bit 3 bus released, bit 4 sleep, bit 5 software standby and bit 6 hardware standby. System reset puts the controller in the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| sysRstN | input | 1 | Asynchronous active-low reset of the controller flops |
| resPinN | input | 1 | Asynchronous active-low reset pin |
| stbyPinN | input | 1 | Asynchronous active-low hardware standby pin |
| wdtOvf | input | 1 | Watchdog overflow pulse, synchronous |
| sleepStrobe | input | 1 | Sleep instruction executed, one-cycle strobe |
| ssbySel | input | 1 | Standby select: 0 sleep, 1 software standby |
| intIrq | input | N_INT | Internal interrupt requests, asynchronous |
| extIrq | input | N_EXT | External interrupt requests, asynchronous |
| busReq | input | 1 | External bus request, synchronous |
| excDone | input | 1 | Exception handling finished |
| stateOneHot | output | 7 | One-hot operating state |
| intMask | output | 1 | All interrupts masked |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |

## Verification
A synchronous input takes effect on the first rising edge after it is driven. A pin or interrupt change takes effect on the third edge, after the two synchronizer flops and the state register. The mask and clock enables are registered together with the state, so they change on the same edge. The bench drives inputs on falling edges. After each rising edge it advances its own model, which holds a two-deep copy of every asynchronous input and the previous reset level, and it compares all outputs on the following falling edge. The directed cases also check explicitly that the state has not yet changed one edge before its due cycle.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

  localparam int NUM_STATES = 7;
  localparam int STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_RESET  = 3'd0,
    ST_EXC    = 3'd1,
    ST_RUN    = 3'd2,
    ST_BUSREL = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_SWSTBY = 3'd5,
    ST_HWSTBY = 3'd6
  } opState_e;

  // Strobes from control to datapath: levels the output registers load
  typedef struct packed {
    logic maskIrq;
    logic coreOn;
    logic periphOn;
  } outCtl_t;

  // Synchronized pin and request information from datapath to control
  typedef struct packed {
    logic resLevel;
    logic resRise;
    logic stbyLevel;
    logic anyIrq;
    logic anyExtIrq;
  } pinInfo_t;

endpackage

// File: rtl/opstate_sync.sv
module opstate_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/opstate_datapath.sv
module opstate_datapath
  import opstate_pkg::*;
#(
  parameter int N_INT       = 2,
  parameter int N_EXT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             resPinN,
  input  logic             stbyPinN,
  input  logic [N_INT-1:0] intIrq,
  input  logic [N_EXT-1:0] extIrq,
  input  outCtl_t          outCtl,
  output pinInfo_t         pinInfo,
  output logic             intMask,
  output logic             coreClkEn,
  output logic             periphClkEn
);

  localparam int N_IRQ = N_INT + N_EXT;

  logic [1:0]       pinSync;
  logic [N_IRQ-1:0] irqSync;
  logic             resPrev;

  // Pins: bit 1 standby (idle high), bit 0 reset (held asserted until seen)
  opstate_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_pinSync (
    .clk    (clk),
    .sysRstN(sysRstN),
    .din    ({stbyPinN, resPinN}),
    .dout   (pinSync)
  );

  // Requests: external lines occupy the low bits
  opstate_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_irqSync (
    .clk    (clk),
    .sysRstN(sysRstN),
    .din    ({intIrq, extIrq}),
    .dout   (irqSync)
  );

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) resPrev <= 1'b0;
    else          resPrev <= pinSync[0];
  end

  always_comb begin
    pinInfo.resLevel  = pinSync[0];
    pinInfo.resRise   = pinSync[0] & ~resPrev;
    pinInfo.stbyLevel = pinSync[1];
    pinInfo.anyIrq    = |irqSync;
    pinInfo.anyExtIrq = |irqSync[N_EXT-1:0];
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      intMask     <= 1'b1;
      coreClkEn   <= 1'b1;
      periphClkEn <= 1'b1;
    end else begin
      intMask     <= outCtl.maskIrq;
      coreClkEn   <= outCtl.coreOn;
      periphClkEn <= outCtl.periphOn;
    end
  end

  // R4: an edge is reported only on the first cycle of a high level
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!sysRstN)
    pinInfo.resRise |=> !pinInfo.resRise);

endmodule

// File: rtl/opstate_fsm.sv
module opstate_fsm
  import opstate_pkg::*;
(
  input  logic                  clk,
  input  logic                  sysRstN,
  input  pinInfo_t              pinInfo,
  input  logic                  wdtOvf,
  input  logic                  sleepStrobe,
  input  logic                  ssbySel,
  input  logic                  busReq,
  input  logic                  excDone,
  output logic [NUM_STATES-1:0] stateOneHot,
  output outCtl_t               outCtl
);

  opState_e stQ, stD;
  logic     wdtFlagQ, wdtFlagD;
  logic     wdtHit;

  assign wdtHit = wdtOvf && pinInfo.stbyLevel && (stQ != ST_HWSTBY);

  always_comb begin
    stD = stQ;
    if (!pinInfo.stbyLevel) begin
      stD = ST_HWSTBY;
    end else if (stQ == ST_HWSTBY) begin
      if (!pinInfo.resLevel) stD = ST_RESET;
    end else if (!pinInfo.resLevel || wdtOvf) begin
      stD = ST_RESET;
    end else begin
      unique case (stQ)
        ST_RESET:  if (pinInfo.resRise || wdtFlagQ) stD = ST_EXC;
        ST_EXC:    if (excDone) stD = ST_RUN;
        ST_RUN: begin
          if (busReq)           stD = ST_BUSREL;
          else if (sleepStrobe) stD = ssbySel ? ST_SWSTBY : ST_SLEEP;
        end
        ST_BUSREL: if (!busReq) stD = ST_RUN;
        ST_SLEEP:  if (pinInfo.anyIrq) stD = ST_EXC;
        ST_SWSTBY: if (pinInfo.anyExtIrq) stD = ST_EXC;
        default:   stD = ST_RESET;
      endcase
    end
  end

  // Remembers a watchdog-caused reset so it ends without a pin edge
  always_comb begin
    wdtFlagD = 1'b0;
    if (stD == ST_RESET) wdtFlagD = wdtHit || (stQ == ST_RESET && wdtFlagQ);
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      stQ      <= ST_RESET;
      wdtFlagQ <= 1'b0;
    end else begin
      stQ      <= stD;
      wdtFlagQ <= wdtFlagD;
    end
  end

  always_comb begin
    outCtl.maskIrq  = (stD == ST_RESET);
    outCtl.coreOn   = !(stD inside {ST_SLEEP, ST_SWSTBY, ST_HWSTBY});
    outCtl.periphOn = !(stD inside {ST_SWSTBY, ST_HWSTBY});
  end

  always_comb begin
    stateOneHot = '0;
    stateOneHot[stQ] = 1'b1;
  end

  p_stby_priority_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    !pinInfo.stbyLevel |=> (stQ == ST_HWSTBY));

  p_reset_pin_r1: assert property (@(posedge clk) disable iff (!sysRstN)
    (pinInfo.stbyLevel && stQ != ST_HWSTBY && !pinInfo.resLevel) |=> (stQ == ST_RESET));

  p_hw_exit_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    (stQ == ST_HWSTBY && pinInfo.resLevel) |=> (stQ == ST_HWSTBY));

  p_sw_ignores_int_r8: assert property (@(posedge clk) disable iff (!sysRstN)
    (stQ == ST_SWSTBY && pinInfo.stbyLevel && pinInfo.resLevel && !wdtOvf && !pinInfo.anyExtIrq)
      |=> (stQ == ST_SWSTBY));

  p_sleep_entry_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    (stQ == ST_RUN && pinInfo.stbyLevel && pinInfo.resLevel && !wdtOvf && !busReq && sleepStrobe)
      |=> (stQ == ($past(ssbySel) ? ST_SWSTBY : ST_SLEEP)));

  p_wdt_reset_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    (wdtOvf && pinInfo.stbyLevel && stQ != ST_HWSTBY) |=> (stQ == ST_RESET));

endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
#(
  parameter int N_INT       = 2,
  parameter int N_EXT       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  sysRstN,
  input  logic                  resPinN,
  input  logic                  stbyPinN,
  input  logic                  wdtOvf,
  input  logic                  sleepStrobe,
  input  logic                  ssbySel,
  input  logic [N_INT-1:0]      intIrq,
  input  logic [N_EXT-1:0]      extIrq,
  input  logic                  busReq,
  input  logic                  excDone,
  output logic [NUM_STATES-1:0] stateOneHot,
  output logic                  intMask,
  output logic                  coreClkEn,
  output logic                  periphClkEn
);

  outCtl_t  outCtl;
  pinInfo_t pinInfo;

  opstate_datapath #(.N_INT(N_INT), .N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .resPinN    (resPinN),
    .stbyPinN   (stbyPinN),
    .intIrq     (intIrq),
    .extIrq     (extIrq),
    .outCtl     (outCtl),
    .pinInfo    (pinInfo),
    .intMask    (intMask),
    .coreClkEn  (coreClkEn),
    .periphClkEn(periphClkEn)
  );

  opstate_fsm u_fsm (
    .clk        (clk),
    .sysRstN    (sysRstN),
    .pinInfo    (pinInfo),
    .wdtOvf     (wdtOvf),
    .sleepStrobe(sleepStrobe),
    .ssbySel    (ssbySel),
    .busReq     (busReq),
    .excDone    (excDone),
    .stateOneHot(stateOneHot),
    .outCtl     (outCtl)
  );

  p_onehot_r12: assert property (@(posedge clk) disable iff (!sysRstN)
    $countones(stateOneHot) == 1);

  p_mask_in_reset_r3: assert property (@(posedge clk) disable iff (!sysRstN)
    intMask == stateOneHot[ST_RESET]);

  p_core_clk_r11: assert property (@(posedge clk) disable iff (!sysRstN)
    coreClkEn == !(stateOneHot[ST_SLEEP] || stateOneHot[ST_SWSTBY] || stateOneHot[ST_HWSTBY]));

  p_periph_clk_r11: assert property (@(posedge clk) disable iff (!sysRstN)
    periphClkEn == !(stateOneHot[ST_SWSTBY] || stateOneHot[ST_HWSTBY]));

endmodule

// File: tb/opstate_ctrl_bench.sv
module opstate_ctrl_bench;

  localparam int NI = 2;
  localparam int NE = 2;
  localparam int NS = 7;
  // state indices per R12
  localparam int S_RST = 0, S_EXC = 1, S_RUN = 2, S_BUS = 3, S_SLP = 4, S_SWS = 5, S_HWS = 6;

  logic          clk = 1'b0;
  logic          sysRstN = 1'b0;
  logic          resPinN = 1'b1, stbyPinN = 1'b1;
  logic          wdtOvf = 1'b0, sleepStrobe = 1'b0, ssbySel = 1'b0;
  logic [NI-1:0] intIrq = '0;
  logic [NE-1:0] extIrq = '0;
  logic          busReq = 1'b0, excDone = 1'b0;
  logic [NS-1:0] stateOneHot;
  logic          intMask, coreClkEn, periphClkEn;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  opstate_ctrl #(.N_INT(NI), .N_EXT(NE), .SYNC_STAGES(2)) u_opstate_ctrl (
    .clk(clk), .sysRstN(sysRstN), .resPinN(resPinN), .stbyPinN(stbyPinN),
    .wdtOvf(wdtOvf), .sleepStrobe(sleepStrobe), .ssbySel(ssbySel),
    .intIrq(intIrq), .extIrq(extIrq), .busReq(busReq), .excDone(excDone),
    .stateOneHot(stateOneHot), .intMask(intMask), .coreClkEn(coreClkEn),
    .periphClkEn(periphClkEn)
  );

  // Model: two synchronizer stages per asynchronous input, previous reset level
  bit mRes1, mRes2, mResPrev, mStby1, mStby2, mFlag;
  bit [NI-1:0] mInt1, mInt2;
  bit [NE-1:0] mExt1, mExt2;
  int mState;
  string mTag;

  function automatic int nextOf(int s, bit resL, bit rise, bit stbyL, bit flag, bit wdt,
                                bit slp, bit sel, bit bus, bit done, bit anyI, bit anyE,
                                output string tag);
    tag = "R12";
    if (!stbyL) begin tag = "R5"; return S_HWS; end
    if (s == S_HWS) begin tag = "R6"; return resL ? S_HWS : S_RST; end
    if (!resL) begin tag = "R1"; return S_RST; end
    if (wdt) begin tag = "R2"; return S_RST; end
    case (s)
      S_RST: begin tag = "R4"; if (rise || flag) return S_EXC; end
      S_EXC: begin tag = "R10"; if (done) return S_RUN; end
      S_RUN: begin
        tag = "R9";
        if (bus) return S_BUS;
        tag = "R7";
        if (slp) return sel ? S_SWS : S_SLP;
      end
      S_BUS: begin tag = "R9"; if (!bus) return S_RUN; end
      S_SLP: begin tag = "R8"; if (anyI) return S_EXC; end
      S_SWS: begin tag = "R8"; if (anyE) return S_EXC; end
      default: ;
    endcase
    return s;
  endfunction

  task automatic modelReset();
    mRes1 = 0; mRes2 = 0; mResPrev = 0; mStby1 = 1; mStby2 = 1; mFlag = 0;
    mInt1 = '0; mInt2 = '0; mExt1 = '0; mExt2 = '0; mState = S_RST; mTag = "R12";
  endtask

  task automatic modelStep();
    string t;
    int n;
    bit wHit;
    wHit = wdtOvf && mStby2 && (mState != S_HWS);
    n = nextOf(mState, mRes2, mRes2 && !mResPrev, mStby2, mFlag, wdtOvf, sleepStrobe,
               ssbySel, busReq, excDone, (|mInt2) || (|mExt2), |mExt2, t);
    mFlag = (n == S_RST) && (wHit || (mState == S_RST && mFlag));
    mState = n; mTag = t;
    mResPrev = mRes2; mRes2 = mRes1; mRes1 = resPinN;
    mStby2 = mStby1; mStby1 = stbyPinN;
    mInt2 = mInt1; mInt1 = intIrq;
    mExt2 = mExt1; mExt1 = extIrq;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [NS-1:0] eHot;
    eHot = NS'(1) << mState;
    check(stateOneHot === eHot, mTag, "state", int'(stateOneHot), int'(eHot));
    check(intMask === (mState == S_RST), "R3", "intMask", int'(intMask), int'(mState == S_RST));
    check(coreClkEn === !(mState inside {S_SLP, S_SWS, S_HWS}), "R11", "coreClkEn",
          int'(coreClkEn), int'(!(mState inside {S_SLP, S_SWS, S_HWS})));
    check(periphClkEn === !(mState inside {S_SWS, S_HWS}), "R11", "periphClkEn",
          int'(periphClkEn), int'(!(mState inside {S_SWS, S_HWS})));
  endtask

  task automatic cycle(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      modelStep();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic expectState(int idx, string tag);
    logic [NS-1:0] eHot;
    eHot = NS'(1) << idx;
    check(stateOneHot === eHot, tag, "directed state", int'(stateOneHot), int'(eHot));
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; cycle(1); sig = 1'b0;
  endtask

  task automatic toRun();
    excDone = 1'b1; cycle(1); excDone = 1'b0;
    expectState(S_RUN, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    modelReset();
    repeat (3) @(negedge clk);
    // R12 and R3: state after system reset
    expectState(S_RST, "R12");
    check(intMask === 1'b1, "R3", "intMask in reset", int'(intMask), 1);
    sysRstN = 1'b1;

    // R4: reset exception handling starts on the synchronized rising edge
    cycle(2); expectState(S_RST, "R4");
    cycle(1); expectState(S_EXC, "R4");
    toRun();

    // R9: bus request beats sleep strobe, release returns
    busReq = 1'b1; sleepStrobe = 1'b1; cycle(1); sleepStrobe = 1'b0;
    expectState(S_BUS, "R9");
    cycle(3); expectState(S_BUS, "R9");
    busReq = 1'b0; cycle(1); expectState(S_RUN, "R9");

    // R7/R8/R11: software standby ignores internal requests
    ssbySel = 1'b1; pulse(sleepStrobe); expectState(S_SWS, "R7");
    check(coreClkEn === 1'b0 && periphClkEn === 1'b0, "R11", "clocks in sw standby",
          int'({coreClkEn, periphClkEn}), 0);
    intIrq = '1; cycle(6); expectState(S_SWS, "R8");
    intIrq = '0; extIrq = 2'b01; cycle(2); expectState(S_SWS, "R8");
    cycle(1); expectState(S_EXC, "R8");
    extIrq = '0; cycle(3); toRun();

    // R7/R8: sleep wakes on an internal request
    ssbySel = 1'b0; pulse(sleepStrobe); expectState(S_SLP, "R7");
    check(coreClkEn === 1'b0 && periphClkEn === 1'b1, "R11", "clocks in sleep",
          int'({coreClkEn, periphClkEn}), 1);
    intIrq = 2'b10; cycle(3); expectState(S_EXC, "R8");
    intIrq = '0; cycle(3); toRun();

    // R5/R6: standby beats reset; exit only through reset
    stbyPinN = 1'b0; resPinN = 1'b0; cycle(3); expectState(S_HWS, "R5");
    stbyPinN = 1'b1; resPinN = 1'b1; cycle(8); expectState(S_HWS, "R6");
    wdtOvf = 1'b1; cycle(1); wdtOvf = 1'b0; expectState(S_HWS, "R6");
    resPinN = 1'b0; cycle(3); expectState(S_RST, "R6");
    resPinN = 1'b1; cycle(3); expectState(S_EXC, "R4");
    toRun();

    // R2: watchdog pulse
    pulse(wdtOvf); expectState(S_RST, "R2");
    check(intMask === 1'b1, "R3", "intMask after watchdog", int'(intMask), 1);
    cycle(1); expectState(S_EXC, "R2");
    toRun();

    // R1: reset pin from program execution, due on the third edge
    resPinN = 1'b0; cycle(2); expectState(S_RUN, "R1");
    cycle(1); expectState(S_RST, "R1");
    cycle(4); expectState(S_RST, "R4");
    resPinN = 1'b1; cycle(3); expectState(S_EXC, "R4");

    // Random phase: every requirement checked against the model each cycle
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 100 < 2) resPinN = 1'b0;
      else if (!resPinN && $urandom % 4 == 0) resPinN = 1'b1;
      if ($urandom % 200 < 1) stbyPinN = 1'b0;
      else if (!stbyPinN && $urandom % 4 == 0) stbyPinN = 1'b1;
      wdtOvf      = ($urandom % 100) < 1;
      sleepStrobe = ($urandom % 100) < 10;
      ssbySel     = $urandom % 2;
      if ($urandom % 10 == 0) busReq = ~busReq;
      excDone     = ($urandom % 100) < 30;
      for (int b = 0; b < NI; b++) intIrq[b] = ($urandom % 100) < 5;
      for (int b = 0; b < NE; b++) extIrq[b] = ($urandom % 100) < 4;
      cycle(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule